// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block holds two 16-bit compare channels. Each channel watches a free-running counter value that arrives from outside the block. When the counter takes on a new value equal to a channel's compare word, the channel records a match. A match raises that channel's interrupt flag. If the channel's pin drive is enabled, the match also inverts the channel's pin level. Both channels share one control word. That word holds, for each channel, the run bits, flag-enable bits, flags, levels and drive enables, plus one pairing bit. When the pairing bit is set, pin 1 inverts on a match from either channel. This lets two compare points bound a pulse on a single pin.

Software reaches the block through a simple word bus with three registers:

- address 0: compare word of channel 0
- address 1: compare word of channel 1
- address 2: the control word

Reads are combinational. Writes take effect at the clock edge. The counter, the interrupt controller and the pin multiplexing all live outside the block.

Top module: `ocu_pair`

## Requirements
- R1: Bus map, all accesses whole 16-bit words:
  - address 0 is compare word 0, address 1 is compare word 1, and address 2 is the control word;
  - address 3 reads 0 and ignores writes;
  - a compare write reads back unchanged;
  - control bits 15:13 and 3:2 read 0.
- R2: With run bit n set, a cycle in which the counter differs from its previous-cycle value and equals compare word n is a match. A match sets flag n (control bit 6+n) at the next clock edge.
- R3: A match on channel n inverts level n (control bit 8+n) only when drive enable n (control bit 10+n) is 1. Otherwise the level is unchanged.
- R4: While run bit n (control bit n) is 0, channel n produces no flag and no level change.
- R5: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. Output irq[n] is flag n AND flag-enable n (control bit 4+n).
- R6: A control write loads the written levels directly. Output pin_out[n] equals level n when drive enable n is 1, and 0 otherwise.
- R7: Pairing bit behaviour (control bit 12):
  - when it is 1, level 1 inverts on a match of either channel, and only once when both match in the same cycle;
  - when it is 0, each level inverts only on its own channel's match;
  - channel 0 never depends on this bit.
- R8: A counter that holds one value for several cycles gives at most one match. Writing a compare word equal to the current held counter value gives no match.
- R9: When a bus write and a match fall in the same cycle:
  - the match uses the compare word held before the write, and the new word applies from the next cycle;
  - a flag set by the match wins over a written clear;
  - the inversion is applied on top of a written level;
  - the pairing and drive-enable bits in force for the match are the ones held before the write.
- R10: After reset the control word, both compare words, irq and pin_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the word bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| frc_value | input | 16 | Current free-running counter value |
| irq | output | 2 | Interrupt request per channel |
| pin_out | output | 2 | Compare output pins |

## Verification
The hardest case to reach from the ports is a bus write that lands in exactly the same cycle as a match. The stimulus holds the counter one below the compare value, then changes the counter and raises the write strobe on the same falling edge. This is done once for a compare write and once for a control write that both clears the flag and loads a level. The double match under pairing is reached by giving both channels the same compare word. A sweep then walks the counter through every combination of pairing, drive enables and run bits. During the sweep the counter is held on the match value for an even number of cycles, so any repeated inversion would show up in the pin level.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    localparam int OCU_DW  = 16;
    localparam int CTRL_W  = 16;
    localparam int NCH     = 2;

    localparam int PAIR_BIT = 12;
    localparam int DRV_LSB  = 10;
    localparam int LVL_LSB  = 8;
    localparam int FLAG_LSB = 6;
    localparam int FEN_LSB  = 4;
    localparam int RUN_LSB  = 0;

    typedef enum logic [1:0] {
        ADDR_CMP0 = 2'd0,
        ADDR_CMP1 = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } ocu_addr_e;

    typedef struct packed {
        logic           pair_mode;
        logic [NCH-1:0] drive_en;
        logic [NCH-1:0] level;
        logic [NCH-1:0] flag;
        logic [NCH-1:0] flag_en;
        logic [NCH-1:0] run;
    } ocu_ctrl_t;

    function automatic ocu_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ocu_ctrl_t c;
        c.pair_mode = w[PAIR_BIT];
        c.drive_en  = w[DRV_LSB  +: NCH];
        c.level     = w[LVL_LSB  +: NCH];
        c.flag      = w[FLAG_LSB +: NCH];
        c.flag_en   = w[FEN_LSB  +: NCH];
        c.run       = w[RUN_LSB  +: NCH];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ocu_ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[PAIR_BIT]          = c.pair_mode;
        w[DRV_LSB  +: NCH]   = c.drive_en;
        w[LVL_LSB  +: NCH]   = c.level;
        w[FLAG_LSB +: NCH]   = c.flag;
        w[FEN_LSB  +: NCH]   = c.flag_en;
        w[RUN_LSB  +: NCH]   = c.run;
        return w;
    endfunction

endpackage

// File: rtl/ocu_sample.sv
// Detects a change of the counter value since the previous cycle.
// The previous-value register loads every cycle, reset included, so a
// value held across reset release is not treated as fresh.
module ocu_sample #(
    parameter int DW = ocu_pkg::OCU_DW
) (
    input  logic          clk,
    input  logic [DW-1:0] value,
    output logic          fresh
);
    logic [DW-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= value;
    end

    assign fresh = (value != prev_q);
endmodule

// File: rtl/ocu_cmp_chan.sv
// One compare channel: compare word storage and match detection.
module ocu_cmp_chan #(
    parameter int DW = ocu_pkg::OCU_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count,
    input  logic          fresh,
    input  logic          run,
    output logic [DW-1:0] cmp_q,
    output logic          hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (wr_en) begin
            cmp_q <= wdata;
        end
    end

    // Match uses the word held this cycle; a same-cycle write lands next cycle.
    assign hit = run && fresh && (count == cmp_q);
endmodule

// File: rtl/ocu_ctrl.sv
// Shared control word: flags, levels and enables for the channel pair.
module ocu_ctrl
    import ocu_pkg::*;
#(
    parameter int DW = OCU_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] hit,
    output ocu_ctrl_t      ctrl_q
);
    ocu_ctrl_t      wr_view;
    ocu_ctrl_t      base;
    ocu_ctrl_t      ctrl_d;
    logic [NCH-1:0] toggle;

    always_comb begin
        wr_view = unpack_ctrl(wdata[CTRL_W-1:0]);
        base    = ctrl_q;
        if (wr_en) begin
            base      = wr_view;
            base.flag = ctrl_q.flag & wr_view.flag;
        end
    end

    // Even channels follow their own match; odd channels may also follow
    // their even neighbour when pairing is on (counted once on a double hit).
    for (genvar g = 0; g < NCH; g++) begin : g_tog
        if (g % 2 == 0) begin : g_even
            assign toggle[g] = hit[g];
        end else begin : g_odd
            assign toggle[g] = ctrl_q.pair_mode ? (hit[g] | hit[g-1]) : hit[g];
        end
    end

    always_comb begin
        ctrl_d       = base;
        ctrl_d.flag  = base.flag | hit;
        ctrl_d.level = base.level ^ (toggle & ctrl_q.drive_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/ocu_pair.sv
module ocu_pair
    import ocu_pkg::*;
#(
    parameter int DW = OCU_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_we,
    input  logic [1:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [DW-1:0]  frc_value,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] pin_out
);
    logic                    fresh;
    logic [NCH-1:0]          hit;
    logic [NCH-1:0][DW-1:0]  cmp_q;
    ocu_ctrl_t               ctrl_q;
    logic                    ctrl_wr;

    ocu_sample #(.DW(DW)) u_sample (
        .clk   (clk),
        .value (frc_value),
        .fresh (fresh)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [1:0] MY_ADDR = 2'(g);
        ocu_cmp_chan #(.DW(DW)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_we && (bus_addr == MY_ADDR)),
            .wdata (bus_wdata),
            .count (frc_value),
            .fresh (fresh),
            .run   (ctrl_q.run[g]),
            .cmp_q (cmp_q[g]),
            .hit   (hit[g])
        );
    end

    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);

    ocu_ctrl #(.DW(DW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wdata  (bus_wdata),
        .hit    (hit),
        .ctrl_q (ctrl_q)
    );

    always_comb begin
        case (ocu_addr_e'(bus_addr))
            ADDR_CMP0: bus_rdata = cmp_q[0];
            ADDR_CMP1: bus_rdata = cmp_q[1];
            ADDR_CTRL: bus_rdata = DW'(pack_ctrl(ctrl_q));
            default:   bus_rdata = '0;
        endcase
    end

    assign irq     = ctrl_q.flag & ctrl_q.flag_en;
    assign pin_out = ctrl_q.level & ctrl_q.drive_en;
endmodule

// File: rtl/ocu_pair_chk.sv
module ocu_pair_chk
    import ocu_pkg::*;
#(
    parameter int DW = OCU_DW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [1:0]             bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    input  logic [DW-1:0]          frc_value,
    input  ocu_ctrl_t              ctrl_q,
    input  logic [NCH-1:0][DW-1:0] cmp_q,
    input  logic [NCH-1:0]         pin_out,
    input  logic [NCH-1:0]         irq
);
    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R2 / R4: a flag only rises after an equal counter on a running channel
        assert_flag_cause_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(ctrl_q.flag[n]) |->
                ($past(frc_value) == $past(cmp_q[n])) && $past(ctrl_q.run[n]));

        // R5: a flag falls only through a control write carrying 0 in its bit
        assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(ctrl_q.flag[n]) |->
                $past(ctrl_wr) && !$past(bus_wdata[FLAG_LSB+n]));

        // R3: without a control write, a level change needs the drive enable
        assert_level_needs_drive_R3: assert property (@(posedge clk) disable iff (rst)
            ((ctrl_q.level[n] != $past(ctrl_q.level[n])) && !$past(ctrl_wr)) |->
                $past(ctrl_q.drive_en[n]));

        // R5: no request without its enable
        assert_irq_enable_R5: assert property (@(posedge clk) disable iff (rst)
            irq[n] |-> ctrl_q.flag_en[n]);

        // R6: an undriven pin stays low
        assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q.drive_en[n] |-> !pin_out[n]);
    end

    // R8: a counter unchanged over the previous cycle gives no inversion
    assert_held_counter_R8: assert property (@(posedge clk) disable iff (rst)
        (($past(frc_value) == $past(frc_value, 2)) && !$past(ctrl_wr)) |->
            $stable(ctrl_q.level));
endmodule

bind ocu_pair ocu_pair_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .frc_value (frc_value),
    .ctrl_q    (ctrl_q),
    .cmp_q     (cmp_q),
    .pin_out   (pin_out),
    .irq       (irq)
);

// File: tb/ocu_pair_test.sv
module ocu_pair_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] frc = 16'd0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;
    logic [1:0]  pin_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ocu_pair uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .frc_value (frc),
        .irq       (irq),
        .pin_out   (pin_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        @(negedge clk);
        frc = v;
    endtask

    function automatic logic [15:0] cw(input logic mode, input logic [1:0] de,
                                       input logic [1:0] lvl, input logic [1:0] fl,
                                       input logic [1:0] fe, input logic [1:0] run);
        return {3'b000, mode, de, lvl, fl, fe, 2'b00, run};
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        rd(2, d); check("R10 ctrl after reset", d, 16'h0000);
        rd(0, d); check("R10 cmp0 after reset", d, 16'h0000);
        rd(1, d); check("R10 cmp1 after reset", d, 16'h0000);
        check("R10 pins/irq after reset", {12'd0, pin_out, irq}, 16'h0000);

        // R1: register map and readback
        wr(0, 16'hA5C3); rd(0, d); check("R1 cmp0 readback", d, 16'hA5C3);
        wr(1, 16'h1234); rd(1, d); check("R1 cmp1 readback", d, 16'h1234);
        wr(2, 16'hFFFF); rd(2, d); check("R1 ctrl unused bits zero", d, 16'h1F33);
        wr(3, 16'hBEEF); rd(3, d); check("R1 address 3 reads zero", d, 16'h0000);
        rd(0, d); check("R1 address 3 write ignored", d, 16'hA5C3);
        wr(2, 16'h0000);

        // R2 R3 R4 R7 R8: sweep of pairing, drive enables, run bits, compare overlap
        wr(0, 16'd10);
        for (int mode = 0; mode < 2; mode++) begin
            for (int de = 0; de < 4; de++) begin
                for (int run = 0; run < 4; run++) begin
                    for (int same = 0; same < 2; same++) begin
                        logic m0, m1, c1;
                        logic [1:0] lvl, fl;
                        set_cnt(16'd0);
                        wr(1, same ? 16'd10 : 16'd20);
                        wr(2, cw(mode[0], de[1:0], 2'b00, 2'b00, 2'b11, run[1:0]));
                        for (int v = 1; v < 32; v++) begin
                            set_cnt(16'(v));
                            if (v == 10) @(negedge clk); // held two cycles (R8)
                        end
                        @(negedge clk);
                        m0 = run[0];
                        m1 = run[1];
                        if (mode[0]) c1 = same ? (m0 | m1) : (m0 ^ m1);
                        else         c1 = m1;
                        lvl = {de[1] & c1, de[0] & m0};
                        fl  = {m1, m0};
                        rd(2, d);
                        check($sformatf("R7 R2 R3 R4 R8 ctrl mode=%0d de=%0d run=%0d same=%0d",
                                        mode, de, run, same),
                              d, cw(mode[0], de[1:0], lvl, fl, 2'b11, run[1:0]));
                        check($sformatf("R6 pins mode=%0d de=%0d run=%0d same=%0d",
                                        mode, de, run, same),
                              {14'd0, pin_out}, {14'd0, lvl & de[1:0]});
                        check($sformatf("R5 irq mode=%0d de=%0d run=%0d same=%0d",
                                        mode, de, run, same),
                              {14'd0, irq}, {14'd0, fl});
                    end
                end
            end
        end

        // R5: flag clear semantics and request gating
        wr(0, 16'd40);
        set_cnt(16'd39);
        wr(2, cw(1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b01));
        set_cnt(16'd40);
        @(negedge clk);
        check("R5 irq after match", {14'd0, irq}, 16'h0001);
        wr(2, cw(1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01));
        rd(2, d); check("R5 write 1 keeps flag", d, cw(1'b0, 2'b00, 2'b00, 2'b01, 2'b00, 2'b01));
        check("R5 irq masked", {14'd0, irq}, 16'h0000);
        wr(2, cw(1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b01));
        rd(2, d); check("R5 write 0 clears flag", d, cw(1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b01));
        check("R5 irq after clear", {14'd0, irq}, 16'h0000);

        // R6: direct level load and pin gating
        wr(2, cw(1'b0, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00));
        check("R6 pin gated by drive", {14'd0, pin_out}, 16'h0001);
        wr(2, cw(1'b0, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00));
        check("R6 pins follow level", {14'd0, pin_out}, 16'h0002);

        // R9: compare write colliding with a match
        wr(0, 16'd50);
        set_cnt(16'd49);
        wr(2, cw(1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01));
        @(negedge clk);
        frc = 16'd50; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'd60;
        @(negedge clk);
        bus_we = 1'b0;
        rd(2, d); check("R9 match uses old compare", d, cw(1'b0, 2'b01, 2'b01, 2'b01, 2'b00, 2'b01));
        rd(0, d); check("R9 new compare stored", d, 16'd60);
        set_cnt(16'd60);
        @(negedge clk);
        rd(2, d); check("R9 new compare matches next", d, cw(1'b0, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01));

        // R9: control write colliding with a match
        set_cnt(16'd59);
        @(negedge clk);
        frc = 16'd60; bus_we = 1'b1; bus_addr = 2'd2;
        bus_wdata = cw(1'b0, 2'b01, 2'b01, 2'b00, 2'b00, 2'b01);
        @(negedge clk);
        bus_we = 1'b0;
        rd(2, d); check("R9 set beats clear, toggle on written level", d,
                        cw(1'b0, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01));

        // R8: compare written equal to a held counter gives no match
        wr(2, cw(1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01));
        wr(0, 16'd60);
        repeat (4) @(negedge clk);
        rd(2, d); check("R8 held counter no match", d, cw(1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01));
        check("R8 pin unchanged", {14'd0, pin_out}, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule